// File: doc/BRIEF.md
# Address Translation Result Register

This block sits on a coprocessor register port and serves two purposes. It holds a 32-bit translation result register that software may write directly or read back. It also carries out "translate this virtual address" commands. A translate command passes the virtual address, a privilege flag and a read/write intent to an external page-walk unit over a valid/ready request channel. The block then waits for that unit's response and packs the outcome into the result register, either as a physical page address or as a compact fault record.

Each command carries a coarse selector (`cmd_crm`), two opcode fields (`cmd_op1`, `cmd_op2`), a direction flag and write data. Malformed commands raise a one-cycle undefined-access pulse. While a translation is in flight, the block lowers `cmd_ready`, so no command of any kind is accepted. A read of the result register therefore waits until the update has landed. When the translation enable input is low, a translate command completes at once as an identity mapping and the walker is not used.

Top module: `xpar_unit`

## Requirements
- R1: An accepted command with `cmd_op1` not equal to 0 pulses `undef_err` in the cycle after acceptance and leaves the result register unchanged.
- R2: An accepted write with op1=0, crm=4, op2=0 loads the result register from `cmd_wdata`, with bits [11:7] forced to zero (write 0xFFFFFFFF reads back 0xFFFFF07F).
- R3: An accepted write with op1=0, crm=8, op2[2]=0 and translation enabled raises `walk_req_valid` in the next cycle. The request carries `walk_va`=`cmd_wdata`, `walk_wr`=op2[0] (1 = write) and `walk_user`=op2[1] (1 = user), and holds them stable until `walk_req_ready`.
- R4: A translate write with op2[2]=1 pulses `undef_err`, issues no walk request and leaves the result register unchanged.
- R5: On a walker response with `walk_fault`=0, the result becomes `walk_pa[31:12]` in bits [31:12], with bits [11:2] and bit 0 cleared.
- R6: Bit 1 of a success result equals `walk_super`. When it is set, bits [23:12] are also zero.
- R7: On a walker response with `walk_fault`=1, the result has bit 0 = 1, bits [6:1] = {fsr[12], fsr[10], fsr[3], fsr[2], fsr[1], fsr[0]} of `walk_fsr`, and bits [31:7] = 0.
- R8: An accepted read with op1=0, crm=4, op2=0 pulses `rsp_valid` in the next cycle with `rsp_rdata` equal to the result register. Any other read with op1=0 pulses `undef_err`.
- R9: With `xlate_en`=0, a translate command sets the result to {`cmd_wdata`[31:12], 12'b0} in the cycle after acceptance, issues no walk request and does not raise `busy`.
- R10: `busy` is high from the cycle after a walking translate is accepted until the cycle after the walker response. `cmd_ready` is low whenever `busy` is high.
- R11: After reset the result register is 0, `busy` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlate_en | input | 1 | Address translation enabled |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_op1 | input | 3 | Primary opcode, must be 0 |
| cmd_crm | input | 4 | Register selector (4 = result, 8 = translate) |
| cmd_op2 | input | 3 | Secondary opcode |
| cmd_wdata | input | 32 | Write data or virtual address |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| undef_err | output | 1 | Undefined-access pulse |
| busy | output | 1 | Translation in flight |
| walk_req_valid | output | 1 | Walk request valid |
| walk_req_ready | input | 1 | Walker accepts request |
| walk_va | output | 32 | Virtual address to translate |
| walk_user | output | 1 | Unprivileged access |
| walk_wr | output | 1 | Write access |
| walk_rsp_valid | input | 1 | Walker response valid |
| walk_fault | input | 1 | Response is a fault |
| walk_super | input | 1 | Mapping is a supersection |
| walk_pa | input | 32 | Physical address from walker |
| walk_fsr | input | 13 | Walker fault status code |

## Verification
The hardest case to reach is the window in which a translation is outstanding. It calls for a command to arrive while `busy` is high, and for a walker request that is not accepted at once. The bench plays the walker itself. It holds `walk_req_ready` low for an extra cycle to check that the request stays stable, and it checks that `cmd_ready` stays low before it sends the response. Success and fault responses cover all four legal op2 encodings. The vector values are chosen so that the supersection clearing and the fault-bit repacking touch every bit that changes.

// File: rtl/xpar_pkg.sv
package xpar_pkg;
    localparam int DW        = 32;
    localparam int PG_BITS   = 12;
    localparam int FSR_W     = 13;
    localparam int SS_TOP    = 23;
    localparam int FS_TOP    = 6;
    localparam int RSV_LO    = 7;
    localparam int RSV_HI    = 11;
    localparam logic [3:0] CRM_RES = 4'd4;
    localparam logic [3:0] CRM_XLT = 4'd8;
    localparam logic [DW-1:0] RES_WMASK =
        ~(((DW'(1) << (RSV_HI - RSV_LO + 1)) - DW'(1)) << RSV_LO);

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} xstate_e;

    typedef struct packed {
        logic undef;
        logic res_wr;
        logic res_rd;
        logic xlate;
    } dec_t;

    typedef struct packed {
        xstate_e        st;
        logic [DW-1:0]  res;
        logic [DW-1:0]  va;
        logic           user;
        logic           wr;
        logic           undef;
        logic           rv;
        logic [DW-1:0]  rdata;
    } state_t;
endpackage

// File: rtl/xpar_decode.sv
module xpar_decode
    import xpar_pkg::*;
(
    input  logic       write,
    input  logic [2:0] op1,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output dec_t       dec
);
    always_comb begin
        dec = '0;
        if (op1 != 3'd0) begin
            dec.undef = 1'b1;
        end else if (write) begin
            if (crm == CRM_RES) begin
                if (op2 == 3'd0) dec.res_wr = 1'b1;
                else             dec.undef  = 1'b1;
            end else if (crm == CRM_XLT) begin
                if (op2[2]) dec.undef = 1'b1;
                else        dec.xlate = 1'b1;
            end
        end else begin
            if (crm == CRM_RES && op2 == 3'd0) dec.res_rd = 1'b1;
            else                               dec.undef  = 1'b1;
        end
    end
endmodule

// File: rtl/xpar_format.sv
module xpar_format
    import xpar_pkg::*;
(
    input  logic [DW-1:0]    pa,
    input  logic             super_sec,
    input  logic             fault,
    input  logic [FSR_W-1:0] fsr,
    output logic [DW-1:0]    res
);
    logic [FS_TOP-1:0] fs_packed;

    assign fs_packed = {fsr[12], fsr[10], fsr[3:0]};

    always_comb begin
        res = '0;
        if (fault) begin
            res[FS_TOP:1] = fs_packed;
            res[0]        = 1'b1;
        end else begin
            res[DW-1:PG_BITS] = pa[DW-1:PG_BITS];
            if (super_sec) begin
                res[SS_TOP:PG_BITS] = '0;
                res[1]              = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpar_unit.sv
module xpar_unit
    import xpar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xlate_en,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_write,
    input  logic [2:0]       cmd_op1,
    input  logic [3:0]       cmd_crm,
    input  logic [2:0]       cmd_op2,
    input  logic [DW-1:0]    cmd_wdata,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_rdata,
    output logic             undef_err,
    output logic             busy,
    output logic             walk_req_valid,
    input  logic             walk_req_ready,
    output logic [DW-1:0]    walk_va,
    output logic             walk_user,
    output logic             walk_wr,
    input  logic             walk_rsp_valid,
    input  logic             walk_fault,
    input  logic             walk_super,
    input  logic [DW-1:0]    walk_pa,
    input  logic [FSR_W-1:0] walk_fsr
);
    state_t        state_d, state_q;
    dec_t          dec;
    logic [DW-1:0] walk_res;
    logic          accept;

    xpar_decode u_dec (
        .write (cmd_write),
        .op1   (cmd_op1),
        .crm   (cmd_crm),
        .op2   (cmd_op2),
        .dec   (dec)
    );

    xpar_format u_fmt (
        .pa        (walk_pa),
        .super_sec (walk_super),
        .fault     (walk_fault),
        .fsr       (walk_fsr),
        .res       (walk_res)
    );

    assign cmd_ready      = (state_q.st == ST_IDLE);
    assign accept         = cmd_valid && cmd_ready;
    assign busy           = (state_q.st != ST_IDLE);
    assign walk_req_valid = (state_q.st == ST_REQ);
    assign walk_va        = state_q.va;
    assign walk_user      = state_q.user;
    assign walk_wr        = state_q.wr;
    assign rsp_valid      = state_q.rv;
    assign rsp_rdata      = state_q.rdata;
    assign undef_err      = state_q.undef;

    always_comb begin
        state_d       = state_q;
        state_d.undef = 1'b0;
        state_d.rv    = 1'b0;
        unique case (state_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (dec.undef) begin
                        state_d.undef = 1'b1;
                    end else if (dec.res_wr) begin
                        state_d.res = cmd_wdata & RES_WMASK;
                    end else if (dec.res_rd) begin
                        state_d.rv    = 1'b1;
                        state_d.rdata = state_q.res;
                    end else if (dec.xlate) begin
                        if (!xlate_en) begin
                            state_d.res = {cmd_wdata[DW-1:PG_BITS], {PG_BITS{1'b0}}};
                        end else begin
                            state_d.st   = ST_REQ;
                            state_d.va   = cmd_wdata;
                            state_d.wr   = cmd_op2[0];
                            state_d.user = cmd_op2[1];
                        end
                    end
                end
            end
            ST_REQ: begin
                if (walk_req_ready) state_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (walk_rsp_valid) begin
                    state_d.res = walk_res;
                    state_d.st  = ST_IDLE;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ST_IDLE, default: '0};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/xpar_checker.sv
module xpar_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        cmd_write,
    input logic [2:0]  cmd_op1,
    input logic [3:0]  cmd_crm,
    input logic [2:0]  cmd_op2,
    input logic        undef_err,
    input logic        busy,
    input logic        walk_req_valid,
    input logic        walk_req_ready,
    input logic [31:0] walk_va,
    input logic        walk_rsp_valid,
    input logic        walk_fault,
    input logic [31:0] par_q
);
    a_r1_bad_op1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op1 != 3'd0) |=> (undef_err && $stable(par_q)));

    a_r4_other_state: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_write && cmd_op1 == 3'd0 && cmd_crm == 4'd8 && cmd_op2[2])
        |=> (undef_err && !walk_req_valid && $stable(par_q)));

    a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);

    a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_req_ready) |=> (walk_req_valid && $stable(walk_va)));

    a_r7_fault_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_req_valid && walk_rsp_valid && walk_fault)
        |=> (par_q[0] && par_q[31:7] == 25'd0 && !busy));

    a_r5_ok_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_req_valid && walk_rsp_valid && !walk_fault)
        |=> (!par_q[0] && par_q[11:2] == 10'd0 && !busy));
endmodule

bind xpar_unit xpar_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_ready      (cmd_ready),
    .cmd_write      (cmd_write),
    .cmd_op1        (cmd_op1),
    .cmd_crm        (cmd_crm),
    .cmd_op2        (cmd_op2),
    .undef_err      (undef_err),
    .busy           (busy),
    .walk_req_valid (walk_req_valid),
    .walk_req_ready (walk_req_ready),
    .walk_va        (walk_va),
    .walk_rsp_valid (walk_rsp_valid),
    .walk_fault     (walk_fault),
    .par_q          (state_q.res)
);

// File: tb/xpar_unit_test.sv
`timescale 1ns/1ps
module xpar_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [2:0]  cmd_op1 = '0;
    logic [3:0]  cmd_crm = '0;
    logic [2:0]  cmd_op2 = '0;
    logic [31:0] cmd_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        undef_err;
    logic        busy;
    logic        walk_req_valid;
    logic        walk_req_ready = 1'b0;
    logic [31:0] walk_va;
    logic        walk_user;
    logic        walk_wr;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_fault = 1'b0;
    logic        walk_super = 1'b0;
    logic [31:0] walk_pa = '0;
    logic [12:0] walk_fsr = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xpar_unit uut (.*);

    typedef struct packed {
        logic [1:0]  op2;
        logic [31:0] va;
        logic        flt;
        logic        ss;
        logic [31:0] pa;
        logic [12:0] fsr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 32'h1234_5ABC, 1'b0, 1'b0, 32'h8765_4FFF, 13'h0000},
        '{2'd1, 32'hDEAD_B001, 1'b0, 1'b1, 32'hFFFF_F123, 13'h0000},
        '{2'd2, 32'h0000_0FFF, 1'b1, 1'b0, 32'h0000_0000, 13'h1405},
        '{2'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'hFFFF_FFFF, 13'h0BFA},
        '{2'd0, 32'h4000_0000, 1'b1, 1'b1, 32'hAAAA_AAAA, 13'h1FFF},
        '{2'd1, 32'h7654_3210, 1'b0, 1'b0, 32'h0000_1000, 13'h1FFF},
        '{2'd2, 32'hC0DE_C0DE, 1'b0, 1'b1, 32'h0123_4567, 13'h0000},
        '{2'd3, 32'h0BAD_F00D, 1'b1, 1'b0, 32'h0000_0000, 13'h0409}
    };

    function automatic logic [31:0] model_res(vec_t v);
        logic [31:0] r;
        r = '0;
        if (v.flt) begin
            r = {25'd0, v.fsr[12], v.fsr[10], v.fsr[3], v.fsr[2], v.fsr[1], v.fsr[0], 1'b1};
        end else begin
            r = {v.pa[31:12], 12'd0};
            if (v.ss) begin
                r[23:12] = '0;
                r[1] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic w, input logic [2:0] o1, input logic [3:0] crm,
                         input logic [2:0] o2, input logic [31:0] d);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_write = w; cmd_op1 = o1; cmd_crm = crm;
        cmd_op2 = o2; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_res(input string req, input logic [31:0] exp);
        issue(1'b0, 3'd0, 4'd4, 3'd0, 32'h0);
        check({req, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
        check(req, rsp_rdata, exp);
    endtask

    task automatic run_vec(vec_t v, input bit stall);
        issue(1'b1, 3'd0, 4'd8, {1'b0, v.op2}, v.va);
        check("R3 req_valid", {31'd0, walk_req_valid}, 32'd1);
        check("R3 va", walk_va, v.va);
        check("R3 wr", {31'd0, walk_wr}, {31'd0, v.op2[0]});
        check("R3 user", {31'd0, walk_user}, {31'd0, v.op2[1]});
        check("R10 busy", {30'd0, busy, cmd_ready}, 32'd2);
        if (stall) begin
            cmd_valid = 1'b1; cmd_write = 1'b0; cmd_op1 = '0; cmd_crm = 4'd4; cmd_op2 = '0;
            @(negedge clk);
            cmd_valid = 1'b0;
            check("R3 req held", {31'd0, walk_req_valid}, 32'd1);
            check("R10 no accept", {30'd0, rsp_valid, undef_err}, 32'd0);
        end
        walk_req_ready = 1'b1;
        @(negedge clk);
        walk_req_ready = 1'b0;
        check("R10 busy waiting", {30'd0, busy, walk_req_valid}, 32'd2);
        walk_rsp_valid = 1'b1; walk_fault = v.flt; walk_super = v.ss;
        walk_pa = v.pa; walk_fsr = v.fsr;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        check("R10 busy released", {30'd0, busy, cmd_ready}, 32'd1);
        read_res(v.flt ? "R7 fault result" : (v.ss ? "R6 supersection result" : "R5 success result"),
                 model_res(v));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 busy/ready", {30'd0, busy, cmd_ready}, 32'd1);
        read_res("R11 reset result", 32'h0);

        // Vector table walk
        foreach (VECS[i]) run_vec(VECS[i], (i % 3) == 1);

        // R2 direct write with reserved bits
        issue(1'b1, 3'd0, 4'd4, 3'd0, 32'hFFFF_FFFF);
        read_res("R2 masked write", 32'hFFFF_F07F);
        issue(1'b1, 3'd0, 4'd4, 3'd0, 32'h1357_9F80);
        read_res("R2 masked write 2", 32'h1357_9000);

        // R1 bad op1 on write and read
        issue(1'b1, 3'd1, 4'd4, 3'd0, 32'h0);
        check("R1 undef write", {31'd0, undef_err}, 32'd1);
        issue(1'b0, 3'd7, 4'd4, 3'd0, 32'h0);
        check("R1 undef read", {30'd0, undef_err, rsp_valid}, 32'd2);
        read_res("R1 result unchanged", 32'h1357_9000);

        // R4 other security state
        for (int o = 4; o < 8; o++) begin
            issue(1'b1, 3'd0, 4'd8, 3'(o), 32'hABCD_E000);
            check("R4 undef no walk", {30'd0, undef_err, walk_req_valid}, 32'd2);
            check("R4 not busy", {31'd0, busy}, 32'd0);
        end
        read_res("R4 result unchanged", 32'h1357_9000);

        // R8 other read selectors
        issue(1'b0, 3'd0, 4'd4, 3'd1, 32'h0);
        check("R8 bad op2 read", {30'd0, undef_err, rsp_valid}, 32'd2);
        issue(1'b0, 3'd0, 4'd8, 3'd0, 32'h0);
        check("R8 bad crm read", {30'd0, undef_err, rsp_valid}, 32'd2);

        // R9 translation disabled
        xlate_en = 1'b0;
        issue(1'b1, 3'd0, 4'd8, 3'd3, 32'h9ABC_DEF1);
        check("R9 no walk", {30'd0, walk_req_valid, busy}, 32'd0);
        read_res("R9 identity result", 32'h9ABC_D000);
        xlate_en = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule